// File: doc/BRIEF.md
# Firmware Mode Call and Return Sequencer

This block controls entry to and exit from a privileged firmware mode. A call request names an 8-bit function code. The block works out the firmware entry point from a base address, records where to come back to, raises the firmware mode bit and issues a PC redirect. A return request supplies a target address. The block takes the mode for the code being resumed from bit 0 of the target, drops the interrupt-in-progress flag, kills any load-locked reservation, and redirects to the target with its two low bits cleared.

Requests are one-cycle pulses. All results are registered and appear on the clock edge that samples the request. The saved return address stores the caller's mode in bit 0, so a return through that saved address puts the caller back in the mode it called from. A legacy return form reads its target from the saved address rather than from the operand. If a call and a return arrive together, the call is carried out, the return has no effect, and a clash pulse is raised.

Top module: `priv_seq`

## Requirements
- R1: A call whose code has bit 7 = 0 loads `pc_next` with `fw_base + 0x1000 + code*64` and pulses `pc_load`.
- R2: A call whose code has bit 7 = 1 loads `pc_next` with `fw_base + 0x2000 + (code-128)*64` and pulses `pc_load`.
- R3: On a call, `saved_ret` becomes `call_pc` with bit 0 ORed with the mode in force before the call (1 = firmware, 0 = normal).
- R4: After any call, `fw_mode` is 1, whether the call came from normal mode or from firmware mode.
- R5: A return loads `pc_next` with the target with bits 1:0 cleared, sets `fw_mode` to bit 0 of the target, and pulses `pc_load`.
- R6: A return pulses `intr_clr` and `lock_kill` for exactly one cycle. A call pulses neither.
- R7: A return with `ret_legacy` = 1 takes its target from `saved_ret` and ignores `ret_target`.
- R8: When `call_req` and `ret_req` are high in the same cycle, only the call takes effect (no `intr_clr`, no `lock_kill`), and `req_clash` pulses.
- R9: In a cycle with no request, `fw_mode` and `saved_ret` hold their values, and `pc_load`, `intr_clr`, `lock_kill` and `req_clash` are 0.
- R10: After reset, `fw_mode` = 1, `saved_ret` = 0, `pc_next` = 0, and every pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | One-cycle firmware call request |
| call_code | input | 8 | Firmware function code |
| call_pc | input | 64 | PC of the calling instruction |
| ret_req | input | 1 | One-cycle return request |
| ret_legacy | input | 1 | Take the return target from the saved address |
| ret_target | input | 64 | Return target operand |
| fw_base | input | 64 | Firmware base address, 16 KiB aligned |
| pc_load | output | 1 | Redirect strobe |
| pc_next | output | 64 | Redirect address |
| fw_mode | output | 1 | Firmware mode bit |
| saved_ret | output | 64 | Saved return address with the caller's mode in bit 0 |
| intr_clr | output | 1 | Clear the interrupt-in-progress flag |
| lock_kill | output | 1 | Set the lock address to all ones (no reservation) |
| req_clash | output | 1 | A call and a return arrived in the same cycle |

## Verification
The bound checker evaluates these rules on every cycle:
- the entry-point arithmetic for both code regions;
- the mode tag in the saved address;
- the forced mode after a call;
- the target alignment and mode restore on a return;
- pulse exclusivity;
- clash resolution;
- that state holds when no request is present.

Some properties span several requests, and only the bench's sequences can show them. One is that a return through the saved address puts the caller back in its original mode. Another is that a sweep of all 256 codes, from both modes and under two base addresses, lands every entry point on its 64-byte slot.

// File: rtl/priv_seq_pkg.sv
package priv_seq_pkg;

    // Resolved action for one cycle of requests
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_CALL  = 2'd1,
        ACT_RET   = 2'd2,
        ACT_CLASH = 2'd3
    } act_e;

endpackage

// File: rtl/priv_req_arb.sv
module priv_req_arb
    import priv_seq_pkg::*;
(
    input  logic call_req,
    input  logic ret_req,
    output act_e act
);
    always_comb begin
        unique case ({call_req, ret_req})
            2'b10:   act = ACT_CALL;
            2'b01:   act = ACT_RET;
            2'b11:   act = ACT_CLASH;
            default: act = ACT_IDLE;
        endcase
    end
endmodule

// File: rtl/priv_entry_gen.sv
module priv_entry_gen #(
    parameter int unsigned XLEN        = 64,
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned SLOT_LG     = 6,
    parameter int unsigned LO_REGION   = 32'h1000,
    parameter int unsigned HI_REGION   = 32'h2000,
    parameter bit          BASE_ALIGNED = 1'b1
) (
    input  logic [XLEN-1:0]   base,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   entry
);
    localparam int unsigned IDX_W = CODE_W - 1;
    localparam int unsigned OFF_W = $clog2(HI_REGION + ((2 ** IDX_W) << SLOT_LG));

    logic [OFF_W-1:0] off;

    always_comb begin
        off = (code[CODE_W-1] ? OFF_W'(HI_REGION) : OFF_W'(LO_REGION))
            + (OFF_W'(code[IDX_W-1:0]) << SLOT_LG);
    end

    generate
        if (BASE_ALIGNED) begin : g_merge
            // base low OFF_W bits are zero, so the offset drops in without a carry
            assign entry = {base[XLEN-1:OFF_W], base[OFF_W-1:0] | off};
        end else begin : g_add
            assign entry = base + XLEN'(off);
        end
    endgenerate
endmodule

// File: rtl/priv_ret_decode.sv
module priv_ret_decode #(
    parameter int unsigned XLEN = 64
) (
    input  logic            legacy,
    input  logic [XLEN-1:0] target,
    input  logic [XLEN-1:0] saved,
    output logic [XLEN-1:0] dest,
    output logic            mode
);
    logic [XLEN-1:0] sel;

    always_comb begin
        sel  = legacy ? saved : target;
        dest = {sel[XLEN-1:2], 2'b00};
        mode = sel[0];
    end
endmodule

// File: rtl/priv_seq.sv
module priv_seq
    import priv_seq_pkg::*;
#(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned SLOT_LG  = 6,
    parameter logic [63:0] RESET_PC = 64'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic [CODE_W-1:0] call_code,
    input  logic [XLEN-1:0]   call_pc,
    input  logic              ret_req,
    input  logic              ret_legacy,
    input  logic [XLEN-1:0]   ret_target,
    input  logic [XLEN-1:0]   fw_base,
    output logic              pc_load,
    output logic [XLEN-1:0]   pc_next,
    output logic              fw_mode,
    output logic [XLEN-1:0]   saved_ret,
    output logic              intr_clr,
    output logic              lock_kill,
    output logic              req_clash
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] saved;
        logic            mode;
        logic            load;
        logic            iclr;
        logic            lkill;
        logic            clash;
    } st_t;

    st_t st_d, st_q;

    act_e            act;
    logic [XLEN-1:0] entry;
    logic [XLEN-1:0] ret_dest;
    logic            ret_mode;

    priv_req_arb u_arb (
        .call_req (call_req),
        .ret_req  (ret_req),
        .act      (act)
    );

    priv_entry_gen #(
        .XLEN    (XLEN),
        .CODE_W  (CODE_W),
        .SLOT_LG (SLOT_LG)
    ) u_entry (
        .base  (fw_base),
        .code  (call_code),
        .entry (entry)
    );

    priv_ret_decode #(
        .XLEN (XLEN)
    ) u_ret (
        .legacy (ret_legacy),
        .target (ret_target),
        .saved  (st_q.saved),
        .dest   (ret_dest),
        .mode   (ret_mode)
    );

    always_comb begin
        st_d       = st_q;
        st_d.load  = 1'b0;
        st_d.iclr  = 1'b0;
        st_d.lkill = 1'b0;
        st_d.clash = 1'b0;
        unique case (act)
            ACT_CALL, ACT_CLASH: begin
                st_d.pc    = entry;
                st_d.saved = call_pc | XLEN'(st_q.mode);
                st_d.mode  = 1'b1;
                st_d.load  = 1'b1;
                st_d.clash = (act == ACT_CLASH);
            end
            ACT_RET: begin
                st_d.pc    = ret_dest;
                st_d.mode  = ret_mode;
                st_d.load  = 1'b1;
                st_d.iclr  = 1'b1;
                st_d.lkill = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.pc    <= XLEN'(RESET_PC);
            st_q.mode  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_load   = st_q.load;
    assign pc_next   = st_q.pc;
    assign fw_mode   = st_q.mode;
    assign saved_ret = st_q.saved;
    assign intr_clr  = st_q.iclr;
    assign lock_kill = st_q.lkill;
    assign req_clash = st_q.clash;
endmodule

// File: rtl/priv_seq_chk.sv
module priv_seq_chk #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_req,
    input logic [CODE_W-1:0] call_code,
    input logic [XLEN-1:0]   call_pc,
    input logic              ret_req,
    input logic              ret_legacy,
    input logic [XLEN-1:0]   ret_target,
    input logic [XLEN-1:0]   fw_base,
    input logic              pc_load,
    input logic [XLEN-1:0]   pc_next,
    input logic              fw_mode,
    input logic [XLEN-1:0]   saved_ret,
    input logic              intr_clr,
    input logic              lock_kill,
    input logic              req_clash
);
    logic [XLEN-1:0] exp_entry;
    logic [XLEN-1:0] exp_tgt;

    always_comb begin
        if (call_code[CODE_W-1])
            exp_entry = fw_base + XLEN'(32'h2000) + XLEN'(({1'b0, call_code} - 9'd128) * 64);
        else
            exp_entry = fw_base + XLEN'(32'h1000) + XLEN'(call_code) * 64;
        exp_tgt = ret_legacy ? saved_ret : ret_target;
    end

    // R1 R2: entry point for both code regions
    assert_entry_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> pc_load && pc_next == $past(exp_entry));

    assert_saved_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> saved_ret == ($past(call_pc) | XLEN'($past(fw_mode))));

    assert_call_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> fw_mode);

    // R5 R7: return target alignment and mode restore
    assert_ret_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req) |=> pc_load && pc_next[1:0] == 2'b00
            && pc_next[XLEN-1:2] == $past(exp_tgt[XLEN-1:2])
            && fw_mode == $past(exp_tgt[0]));

    assert_ret_pulses_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req) |=> intr_clr && lock_kill ##1 (!intr_clr || $past(ret_req && !call_req)));

    assert_call_nopulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> !intr_clr && !lock_kill);

    assert_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && ret_req) |=> req_clash && fw_mode);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_req && !ret_req) |=> $stable(fw_mode) && $stable(saved_ret)
            && !pc_load && !intr_clr && !lock_kill && !req_clash);

    assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_clash, intr_clr}));
endmodule

bind priv_seq priv_seq_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_req   (call_req),
    .call_code  (call_code),
    .call_pc    (call_pc),
    .ret_req    (ret_req),
    .ret_legacy (ret_legacy),
    .ret_target (ret_target),
    .fw_base    (fw_base),
    .pc_load    (pc_load),
    .pc_next    (pc_next),
    .fw_mode    (fw_mode),
    .saved_ret  (saved_ret),
    .intr_clr   (intr_clr),
    .lock_kill  (lock_kill),
    .req_clash  (req_clash)
);

// File: tb/tb_priv_seq.sv
`timescale 1ns/1ps
module tb_priv_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0;
    logic [7:0]  call_code = '0;
    logic [63:0] call_pc = '0;
    logic        ret_req = 1'b0;
    logic        ret_legacy = 1'b0;
    logic [63:0] ret_target = '0;
    logic [63:0] fw_base = '0;
    logic        pc_load;
    logic [63:0] pc_next;
    logic        fw_mode;
    logic [63:0] saved_ret;
    logic        intr_clr;
    logic        lock_kill;
    logic        req_clash;

    int errors = 0;
    int checks = 0;
    logic        m_mode;
    logic [63:0] m_saved;

    always #2 clk = ~clk;

    priv_seq dut (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_code(call_code),
        .call_pc(call_pc), .ret_req(ret_req), .ret_legacy(ret_legacy),
        .ret_target(ret_target), .fw_base(fw_base), .pc_load(pc_load),
        .pc_next(pc_next), .fw_mode(fw_mode), .saved_ret(saved_ret),
        .intr_clr(intr_clr), .lock_kill(lock_kill), .req_clash(req_clash)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_of(input logic [63:0] base, input int code);
        if (code >= 128) return base + 64'h2000 + 64'(code - 128) * 64;
        return base + 64'h1000 + 64'(code) * 64;
    endfunction

    task automatic do_call(input int code, input logic [63:0] pc);
        @(negedge clk);
        call_req = 1'b1; call_code = 8'(code); call_pc = pc;
        @(negedge clk);
        call_req = 1'b0;
        check(code >= 128 ? "R2 entry" : "R1 entry", pc_next, entry_of(fw_base, code));
        check("R1 pc_load", 64'(pc_load), 64'd1);
        m_saved = pc | 64'(m_mode);
        check("R3 saved tag", saved_ret, m_saved);
        m_mode = 1'b1;
        check("R4 mode after call", 64'(fw_mode), 64'd1);
        check("R6 no pulses on call", 64'({intr_clr, lock_kill}), 64'd0);
    endtask

    task automatic do_ret(input logic [63:0] tgt, input logic legacy);
        logic [63:0] eff;
        eff = legacy ? m_saved : tgt;
        @(negedge clk);
        ret_req = 1'b1; ret_target = tgt; ret_legacy = legacy;
        @(negedge clk);
        ret_req = 1'b0; ret_legacy = 1'b0;
        m_mode = eff[0];
        check(legacy ? "R7 legacy dest" : "R5 ret dest", pc_next, eff & ~64'd3);
        check(legacy ? "R7 legacy mode" : "R5 ret mode", 64'(fw_mode), 64'(m_mode));
        check("R6 ret pulses", 64'({intr_clr, lock_kill, pc_load}), 64'd7);
        @(negedge clk);
        check("R6 pulses one cycle", 64'({intr_clr, lock_kill}), 64'd0);
        check("R9 idle hold mode", 64'(fw_mode), 64'(m_mode));
        check("R9 idle hold saved", saved_ret, m_saved);
        check("R9 idle no load", 64'(pc_load), 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset mode", 64'(fw_mode), 64'd1);
        check("R10 reset saved", saved_ret, 64'd0);
        check("R10 reset pc", pc_next, 64'd0);
        check("R10 reset pulses", 64'({pc_load, intr_clr, lock_kill, req_clash}), 64'd0);
        rst_n = 1'b1;
        m_mode = 1'b1;
        m_saved = '0;

        for (int b = 0; b < 2; b++) begin
            fw_base = (b == 0) ? 64'h0 : 64'h0000_1234_5678_C000;
            // sweep from firmware mode
            for (int c = 0; c < 256; c++) begin
                do_call(c, 64'h0001_0000 + 64'(c) * 4);
            end
            // sweep from normal mode: return to normal first, then call
            for (int c = 0; c < 256; c++) begin
                do_ret(64'h4000_0000_0000_0000 + 64'(c) * 8 + 64'd2, 1'b0);
                do_call(c, 64'h0008_0000 + 64'(c) * 4);
                // legacy return through the saved tag restores normal mode (R7)
                if (c % 4 == 0) do_ret(64'hDEAD_BEEF_0000_0001, 1'b1);
            end
        end

        // legacy return from a firmware-mode call restores firmware mode (R7)
        do_call(5, 64'h0000_0000_0000_2000);
        do_call(6, 64'h0000_0000_0000_3000);
        do_ret(64'h0, 1'b1);

        // R8: simultaneous call and return
        do_ret(64'h0000_0000_0000_5000, 1'b0);
        @(negedge clk);
        call_req = 1'b1; call_code = 8'h83; call_pc = 64'h7700;
        ret_req = 1'b1; ret_target = 64'h9001;
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0;
        check("R8 clash pulse", 64'(req_clash), 64'd1);
        check("R8 call wins pc", pc_next, entry_of(fw_base, 8'h83));
        check("R8 call wins mode", 64'(fw_mode), 64'd1);
        check("R8 call wins saved", saved_ret, 64'h7700);
        check("R8 no ret pulses", 64'({intr_clr, lock_kill}), 64'd0);
        @(negedge clk);
        check("R9 clash cleared", 64'(req_clash), 64'd0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule